// File: doc/BRIEF.md
# Audio Sample Input Formatter FIFO

This block sits between a bus master and an audio line serializer. Software, or a DMA channel, writes 32-bit words to one shared data register. Each word is cut to the programmed number of bytes per sample. If big-endian order is chosen, those bytes are put back in order. The result is then trimmed to the programmed valid-bit width and placed either at the bottom or at the top of a 24-bit sample. The shaped sample is tagged with a channel number and queued in an eight-entry FIFO.

The serializer asks for a sample on a given channel. It gets the sample one cycle later only if the head entry belongs to that channel. Otherwise the request is counted as an underrun. In dual-channel mode, accepted writes are tagged with channel 0 and channel 1 in turn. In mono mode every write is tagged with channel 0.

Level and event flags collect in a sticky status register that is cleared when read. An enable/disable pair of mask writes decides which flags drive the interrupt line. A control strobe either empties the FIFO or returns the whole block to its reset state.

Top module: `audio_in_formatter`

## Requirements
- R1: After reset the MODE register (index 1) reads 0, the IMASK register (index 5) reads 0, irq is low and pop_ack is low.
- R2: MODE keeps only these bits: 0 transmit enable, 1 dual, 2 big endian, 3 MSB justify, 5:4 access mode, 13:8 valid bits, 19:16 chunk size, 24 and 25 channel validity, 27 null-frame disable, 29:28 bytes-per-sample minus one. All other bits read 0, so writing all ones reads back 0x3B0F3F3F.
- R3: A write to DATA (index 2) uses the low N bytes of the word, where N is bytes-per-sample. With big endian selected, byte k of the sample is taken from byte N-1-k of the word.
- R4: Only the low V bits of the reordered value are kept, where V is the valid-bit count (capped at 32). LSB justification gives those bits zero-extended and cut to 24 bits. MSB justification puts the top valid bit at bit 23.
- R5: The FIFO holds 8 samples and returns them in write order. A DATA write to a full FIFO is dropped and sets status bit 5 (overflow).
- R6: While transmit enable is set, a pop on channel c succeeds only if the FIFO is not empty and the head entry is tagged c. On success, pop_ack and pop_smp are driven in the next cycle. On failure, pop_ack stays low and status bits 4 and 11+c are set. While transmit enable is clear, pops have no effect at all.
- R7: In dual mode, accepted writes are tagged 0, 1, 0, … starting from 0. In mono mode every write is tagged 0. Status bit 8+c is set while the head entry is tagged c.
- R8: Status bits are sticky. Bit 0 is not full, 1 is empty and 2 is full. Reading ISTAT (index 6) returns the bits and clears them, after which any level that still holds sets its bit again.
- R9: Writing ones to IEN (index 3) sets mask bits and writing ones to IDIS (index 4) clears them. irq is high when any status bit with a set mask bit is high.
- R10: CTRL (index 0) bit 1 empties the FIFO and restarts channel alternation at 0. MODE is left unchanged.
- R11: CTRL bit 0 clears MODE, the mask, the status, the FIFO and the pop outputs.
- R12: Status bit 3 (chunk) is set while the free FIFO space is at least the chunk size. A chunk size of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears ISTAT when it is read) |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pop_req | input | 1 | Serializer sample request |
| pop_ch | input | 1 | Channel requested |
| pop_ack | output | 1 | Sample delivered, one cycle after the request |
| pop_smp | output | 24 | Delivered sample |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that a read and a write never happen in the same cycle. This is what lets a single shared index select both paths. It also means a FIFO overflow can never coincide with a clear or a reset strobe. The bench drives each bus access as a one-cycle pulse with the other strobe held low, so it always stays inside this assumption. Serializer pops, on the other hand, are allowed at any time and may collide with bus traffic, so the properties cover those collisions.

// File: rtl/afmt_pkg.sv
package afmt_pkg;
  localparam int DW     = 32;
  localparam int SW     = 24;
  localparam int ADDR_W = 3;
  localparam int IRQ_W  = 14;
  localparam int NCH    = 2;

  typedef logic [ADDR_W-1:0] reg_idx_t;
  localparam reg_idx_t REG_CTRL  = 3'd0;
  localparam reg_idx_t REG_MODE  = 3'd1;
  localparam reg_idx_t REG_DATA  = 3'd2;
  localparam reg_idx_t REG_IEN   = 3'd3;
  localparam reg_idx_t REG_IDIS  = 3'd4;
  localparam reg_idx_t REG_IMASK = 3'd5;
  localparam reg_idx_t REG_ISTAT = 3'd6;

  // mode field positions
  localparam int MB_TXEN  = 0;
  localparam int MB_DUAL  = 1;
  localparam int MB_BIG   = 2;
  localparam int MB_MSB   = 3;
  localparam int MB_VB    = 8;
  localparam int MB_CHK   = 16;
  localparam int MB_BPS   = 28;
  localparam logic [DW-1:0] MODE_WMASK = 32'h3B0F_3F3F;

  // status bit positions
  localparam int IRQ_RDY   = 0;
  localparam int IRQ_EMPTY = 1;
  localparam int IRQ_FULL  = 2;
  localparam int IRQ_CHUNK = 3;
  localparam int IRQ_UDR   = 4;
  localparam int IRQ_OVR   = 5;
  localparam int IRQ_CHRDY = 8;
  localparam int IRQ_CHUDR = 11;

  typedef struct packed {
    logic          ch;
    logic [SW-1:0] smp;
  } fifo_ent_t;

  // byte selection, optional reordering, valid-bit trim, justification
  function automatic logic [SW-1:0] fmt_sample(input logic [DW-1:0] w,
                                               input logic [1:0] bytes_m1,
                                               input logic big,
                                               input logic msb,
                                               input logic [5:0] vbits);
    logic [DW-1:0] kept, ordered, masked, topa;
    int nb, v;
    nb = int'(bytes_m1) + 1;
    kept = (nb == 4) ? w : (w & ((32'd1 << (8 * nb)) - 32'd1));
    ordered = kept;
    if (big) begin
      ordered = '0;
      for (int k = 0; k < 4; k++) begin
        if (k < nb) ordered[8*k +: 8] = kept[8*(nb-1-k) +: 8];
      end
    end
    v = (vbits > 6'd32) ? 32 : int'(vbits);
    masked = (v == 32) ? ordered : (ordered & ((32'd1 << v) - 32'd1));
    if (msb) begin
      topa = (v == 0) ? '0 : (masked << (32 - v));
      return topa[DW-1 -: SW];
    end
    return masked[SW-1:0];
  endfunction
endpackage

// File: rtl/afmt_shaper.sv
module afmt_shaper
  import afmt_pkg::*;
(
  input  logic [DW-1:0] word,
  input  logic [1:0]    bytes_m1,
  input  logic          big,
  input  logic          msb,
  input  logic [5:0]    vbits,
  output logic [SW-1:0] smp
);
  assign smp = fmt_sample(word, bytes_m1, big, msb, vbits);
endmodule

// File: rtl/afmt_fifo.sv
module afmt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 25
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         full,
  output logic                         empty
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= din;
  end

  assign head  = mem[rp];
  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/afmt_irq.sv
module afmt_irq #(
  parameter int IW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic [IW-1:0] set_vec,
  input  logic          en_wr,
  input  logic          dis_wr,
  input  logic [IW-1:0] wbits,
  input  logic          rd_clr,
  output logic [IW-1:0] isr,
  output logic [IW-1:0] imr,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0;
      imr <= '0;
    end else if (srst) begin
      isr <= '0;
      imr <= '0;
    end else begin
      isr <= (rd_clr ? '0 : isr) | set_vec;
      if (en_wr)  imr <= imr | wbits;
      if (dis_wr) imr <= imr & ~wbits;
    end
  end

  assign irq = |(isr & imr);
endmodule

// File: rtl/audio_in_formatter.sv
module audio_in_formatter
  import afmt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              pop_req,
  input  logic              pop_ch,
  output logic              pop_ack,
  output logic [SW-1:0]     pop_smp,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int ENT_W = $bits(fifo_ent_t);

  // decoded strobes and named events
  logic wr_ctrl, wr_mode, wr_data, wr_ien, wr_idis, rd_stat;
  logic soft_rst, fifo_clr, mask_wr;
  logic push_ok, push_drop, pop_go, pop_ok, pop_miss;

  logic [DW-1:0]    mode_q;
  logic             next_ch;
  logic [SW-1:0]    shaped;
  fifo_ent_t        head, din;
  logic [ENT_W-1:0] head_raw;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_full, fifo_empty;
  logic [IRQ_W-1:0] ev, isr, imr;

  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_mode = bus_wr && (bus_addr == REG_MODE);
  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign wr_ien  = bus_wr && (bus_addr == REG_IEN);
  assign wr_idis = bus_wr && (bus_addr == REG_IDIS);
  assign rd_stat = bus_rd && (bus_addr == REG_ISTAT);

  assign soft_rst = wr_ctrl && bus_wdata[0];
  assign fifo_clr = wr_ctrl && (bus_wdata[0] || bus_wdata[1]);
  assign mask_wr  = wr_ien || wr_idis || soft_rst;

  wire tx_en     = mode_q[MB_TXEN];
  wire dual      = mode_q[MB_DUAL];
  wire [3:0] chk = mode_q[MB_CHK +: 4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= '0;
    else if (soft_rst) mode_q <= '0;
    else if (wr_mode)  mode_q <= bus_wdata & MODE_WMASK;
  end

  afmt_shaper u_shape (
    .word     (bus_wdata),
    .bytes_m1 (mode_q[MB_BPS +: 2]),
    .big      (mode_q[MB_BIG]),
    .msb      (mode_q[MB_MSB]),
    .vbits    (mode_q[MB_VB +: 6]),
    .smp      (shaped)
  );

  assign push_ok   = wr_data && !fifo_full;
  assign push_drop = wr_data && fifo_full;
  assign pop_go    = pop_req && tx_en;
  assign pop_ok    = pop_go && !fifo_empty && (head.ch == pop_ch);
  assign pop_miss  = pop_go && !pop_ok;

  assign din.ch  = dual ? next_ch : 1'b0;
  assign din.smp = shaped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               next_ch <= 1'b0;
    else if (fifo_clr)        next_ch <= 1'b0;
    else if (push_ok && dual) next_ch <= ~next_ch;
  end

  afmt_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (push_ok),
    .pop   (pop_ok),
    .din   (din),
    .head  (head_raw),
    .cnt   (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );
  assign head = fifo_ent_t'(head_raw);

  always_comb begin
    ev = '0;
    ev[IRQ_RDY]   = !fifo_full;
    ev[IRQ_EMPTY] = fifo_empty;
    ev[IRQ_FULL]  = fifo_full;
    ev[IRQ_CHUNK] = (DEPTH - int'(fifo_cnt)) >= ((chk == 4'd0) ? 1 : int'(chk));
    ev[IRQ_UDR]   = pop_miss;
    ev[IRQ_OVR]   = push_drop;
    for (int c = 0; c < NCH; c++) begin
      ev[IRQ_CHRDY + c] = !fifo_empty && (head.ch == 1'(c));
      ev[IRQ_CHUDR + c] = pop_miss && (pop_ch == 1'(c));
    end
  end

  afmt_irq #(.IW(IRQ_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (soft_rst),
    .set_vec (ev),
    .en_wr   (wr_ien),
    .dis_wr  (wr_idis),
    .wbits   (bus_wdata[IRQ_W-1:0]),
    .rd_clr  (rd_stat),
    .isr     (isr),
    .imr     (imr),
    .irq     (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_ack <= 1'b0;
      pop_smp <= '0;
    end else if (soft_rst) begin
      pop_ack <= 1'b0;
      pop_smp <= '0;
    end else begin
      pop_ack <= pop_ok;
      pop_smp <= pop_ok ? head.smp : '0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_MODE:  bus_rdata = mode_q;
      REG_IMASK: bus_rdata = DW'(imr);
      REG_ISTAT: bus_rdata = DW'(isr);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_in_formatter_chk.sv
module audio_in_formatter_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int IW    = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             push_drop,
  input logic             pop_ok,
  input logic             pop_miss,
  input logic             pop_ack,
  input logic             soft_rst,
  input logic             fifo_clr,
  input logic             mask_wr,
  input logic [31:0]      mode_q,
  input logic [IW-1:0]    isr,
  input logic [IW-1:0]    imr
);
  // input assumption: one bus access per cycle
  a_bus_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH);

  a_r5_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok) |=> (fifo_cnt == $past(fifo_cnt)));

  a_r5_ovr_latched: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> isr[5]);

  a_r6_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pop_miss |=> !pop_ack);

  a_r6_hit_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !soft_rst) |=> pop_ack);

  a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(imr));

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fifo_cnt == '0));

  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_q == '0 && imr == '0 && isr == '0 && !pop_ack));
endmodule

bind audio_in_formatter audio_in_formatter_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .IW    (afmt_pkg::IRQ_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .fifo_cnt  (fifo_cnt),
  .push_drop (push_drop),
  .pop_ok    (pop_ok),
  .pop_miss  (pop_miss),
  .pop_ack   (pop_ack),
  .soft_rst  (soft_rst),
  .fifo_clr  (fifo_clr),
  .mask_wr   (mask_wr),
  .mode_q    (mode_q),
  .isr       (isr),
  .imr       (imr)
);

// File: tb/audio_in_formatter_tb.sv
`timescale 1ns/1ps
module audio_in_formatter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pop_req = 1'b0, pop_ch = 1'b0;
  logic        pop_ack;
  logic [23:0] pop_smp;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_in_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pop_req(pop_req), .pop_ch(pop_ch), .pop_ack(pop_ack),
    .pop_smp(pop_smp), .irq(irq)
  );

  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_DATA = 3'd2,
                         A_IEN = 3'd3, A_IDIS = 3'd4, A_IMASK = 3'd5,
                         A_ISTAT = 3'd6;

  // reference model
  logic [23:0] q_s[$];
  bit          q_c[$];
  bit          m_next;
  bit          m_dual;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mode_word(bit en, bit dual, bit big, bit msb,
                                            int vb, int chunk, int nb);
    logic [31:0] m;
    m = 32'(en) | (32'(dual) << 1) | (32'(big) << 2) | (32'(msb) << 3);
    m = m | (32'(vb) << 8) | (32'(chunk) << 16) | (32'(nb - 1) << 28);
    return m;
  endfunction

  function automatic logic [23:0] exp_fmt(logic [31:0] w, int nb, bit big, bit msb, int v);
    logic [31:0] r;
    logic [23:0] o;
    r = '0;
    o = '0;
    for (int k = 0; k < nb; k++) begin
      int src;
      src = big ? (nb - 1 - k) : k;
      for (int b = 0; b < 8; b++) r[8*k + b] = w[8*src + b];
    end
    if (v > 32) v = 32;
    if (!msb) begin
      for (int i = 0; i < 24; i++) if (i < v) o[i] = r[i];
    end else begin
      for (int j = 0; j < 24; j++) if (j < v) o[23 - j] = r[v - 1 - j];
    end
    return o;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pop(input bit c, output logic ack, output logic [23:0] s);
    pop_req = 1'b1; pop_ch = c;
    @(negedge clk);
    pop_req = 1'b0;
    ack = pop_ack;
    s = pop_smp;
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] d;
    logic        a;
    logic [23:0] s;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MODE, d);  chk("R1 mode", d, 0);
    rd(A_IMASK, d); chk("R1 imask", d, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pop_ack", 32'(pop_ack), 0);

    // R2 writable fields
    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, d); chk("R2 mode mask", d, 32'h3B0F_3F3F);
    wr(A_MODE, 0);

    // R3 / R4 directed formatting (mono, enabled)
    wr(A_CTRL, 2);
    wr(A_MODE, mode_word(1, 0, 1, 0, 24, 1, 3));
    wr(A_DATA, 32'hAA11_2233); pop(0, a, s); chk("R3 big 3-byte", 32'(s), 32'h33_2211);
    wr(A_MODE, mode_word(1, 0, 0, 1, 16, 1, 2));
    wr(A_DATA, 32'hFFFF_1234); pop(0, a, s); chk("R4 msb 16", 32'(s), 32'h12_3400);
    wr(A_MODE, mode_word(1, 0, 0, 0, 18, 1, 3));
    wr(A_DATA, 32'hFFFF_FFFF); pop(0, a, s); chk("R4 lsb 18", 32'(s), 32'h03_FFFF);
    wr(A_MODE, mode_word(1, 0, 1, 1, 32, 1, 4));
    wr(A_DATA, 32'h1122_3344); pop(0, a, s); chk("R3 big 32 msb", 32'(s), 32'h44_3322);
    wr(A_MODE, mode_word(1, 0, 0, 1, 8, 1, 1));
    wr(A_DATA, 32'h0000_00C5); pop(0, a, s); chk("R4 msb 8", 32'(s), 32'hC5_0000);

    // R5 / R12 / R8 fill with transmit disabled, chunk 2
    wr(A_CTRL, 2);
    wr(A_MODE, mode_word(0, 0, 0, 0, 32, 2, 4));
    for (int i = 1; i <= 6; i++) wr(A_DATA, 32'(i));
    rd(A_ISTAT, d); rd(A_ISTAT, d);
    chk("R12 chunk with 2 free", 32'(d[3]), 1);
    wr(A_DATA, 7);
    rd(A_ISTAT, d); rd(A_ISTAT, d);
    chk("R12 chunk with 1 free", 32'(d[3]), 0);
    wr(A_DATA, 8);
    wr(A_DATA, 9);
    rd(A_ISTAT, d);
    chk("R5 overflow flag", 32'(d[5]), 1);
    chk("R8 full flag", 32'(d[2]), 1);
    rd(A_ISTAT, d);
    chk("R8 overflow cleared by read", 32'(d[5]), 0);
    chk("R8 full level reasserts", 32'(d[2]), 1);
    chk("R8 ready low when full", 32'(d[0]), 0);
    wr(A_MODE, mode_word(1, 0, 0, 0, 32, 2, 4));
    for (int i = 1; i <= 8; i++) begin
      pop(0, a, s);
      chk("R5 order ack", 32'(a), 1);
      chk("R5 order data", 32'(s), 32'(i));
    end
    pop(0, a, s); chk("R6 empty pop no ack", 32'(a), 0);
    rd(A_ISTAT, d);
    chk("R6 underrun flag", 32'(d[4]), 1);
    chk("R6 ch0 underrun flag", 32'(d[11]), 1);
    chk("R8 empty flag", 32'(d[1]), 1);

    // R6 pops ignored while disabled
    wr(A_MODE, mode_word(0, 0, 0, 0, 32, 1, 4));
    wr(A_DATA, 32'h55);
    rd(A_ISTAT, d);
    pop(0, a, s); chk("R6 disabled no ack", 32'(a), 0);
    rd(A_ISTAT, d); chk("R6 disabled no underrun", 32'(d[4]), 0);
    wr(A_MODE, mode_word(1, 0, 0, 0, 32, 1, 4));
    pop(0, a, s); chk("R6 entry kept", 32'(s), 32'h55);

    // R7 dual alternation
    wr(A_CTRL, 2);
    wr(A_MODE, mode_word(1, 1, 0, 0, 16, 1, 2));
    wr(A_DATA, 32'h0A); wr(A_DATA, 32'h0B); wr(A_DATA, 32'h0C);
    rd(A_ISTAT, d); rd(A_ISTAT, d);
    chk("R7 ch0 ready", 32'(d[8]), 1);
    chk("R7 ch1 not ready", 32'(d[9]), 0);
    pop(1, a, s); chk("R7 wrong channel no ack", 32'(a), 0);
    rd(A_ISTAT, d); chk("R6 ch1 underrun flag", 32'(d[12]), 1);
    pop(0, a, s); chk("R7 first ch0", 32'(s), 32'h0A);
    pop(1, a, s); chk("R7 second ch1", {31'd0, a}, 1); chk("R7 ch1 data", 32'(s), 32'h0B);
    pop(0, a, s); chk("R7 third ch0", 32'(s), 32'h0C);

    // R9 mask and irq
    wr(A_IEN, 32'h23);
    rd(A_IMASK, d); chk("R9 mask set", d, 32'h23);
    wr(A_IDIS, 32'h03);
    rd(A_IMASK, d); chk("R9 mask clear", d, 32'h20);
    rd(A_ISTAT, d);
    chk("R9 irq idle", 32'(irq), 0);
    wr(A_MODE, mode_word(0, 0, 0, 0, 32, 1, 4));
    for (int i = 0; i < 9; i++) wr(A_DATA, 32'(i));
    chk("R9 irq on overflow", 32'(irq), 1);
    wr(A_IDIS, 32'h20);
    chk("R9 irq masked", 32'(irq), 0);

    // R10 FIFO clear and toggle restart
    wr(A_CTRL, 2);
    wr(A_MODE, mode_word(0, 1, 0, 0, 32, 1, 4));
    wr(A_DATA, 32'h11);
    wr(A_CTRL, 2);
    rd(A_MODE, d); chk("R10 mode kept", d, mode_word(0, 1, 0, 0, 32, 1, 4));
    wr(A_DATA, 32'h22);
    wr(A_MODE, mode_word(1, 1, 0, 0, 32, 1, 4));
    pop(0, a, s); chk("R10 toggle restarts at ch0", 32'(s), 32'h22);
    pop(0, a, s); chk("R10 old entry gone", 32'(a), 0);

    // R11 soft reset
    wr(A_IEN, 32'h3FFF);
    wr(A_DATA, 32'h33);
    wr(A_CTRL, 1);
    rd(A_MODE, d);  chk("R11 mode cleared", d, 0);
    rd(A_IMASK, d); chk("R11 mask cleared", d, 0);
    chk("R11 irq low", 32'(irq), 0);
    wr(A_MODE, mode_word(1, 0, 0, 0, 32, 1, 4));
    pop(0, a, s); chk("R11 fifo emptied", 32'(a), 0);

    // R3 R4 R5 R6 R7 random traffic against the model
    wr(A_CTRL, 2);
    q_s.delete(); q_c.delete(); m_next = 0; m_dual = 0;
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        int nb, vb, pick;
        bit big, msb;
        nb = 1 + int'($urandom % 4);
        pick = int'($urandom % 6);
        vb = (pick == 0) ? 8 : (pick == 1) ? 16 : (pick == 2) ? 18 :
             (pick == 3) ? 20 : (pick == 4) ? 24 : 32;
        big = 1'($urandom); msb = 1'($urandom); m_dual = 1'($urandom);
        wr(A_MODE, mode_word(1, m_dual, big, msb, vb, 1, nb));
        d = mode_word(1, m_dual, big, msb, vb, 1, nb);
        for (int k = 0; k < 3; k++) begin
          logic [31:0] w;
          w = $urandom;
          if (q_s.size() < 8) begin
            q_s.push_back(exp_fmt(w, nb, big, msb, vb));
            q_c.push_back(m_dual ? m_next : 1'b0);
            if (m_dual) m_next = ~m_next;
          end
          wr(A_DATA, w);
        end
        bus_wdata = d;
      end else if ($urandom % 2 == 0) begin
        logic [31:0] w;
        int nb, vb;
        w = $urandom;
        rd(A_MODE, d);
        nb = int'(d[29:28]) + 1;
        vb = int'(d[13:8]);
        if (q_s.size() < 8) begin
          q_s.push_back(exp_fmt(w, nb, d[2], d[3], vb));
          q_c.push_back(m_dual ? m_next : 1'b0);
          if (m_dual) m_next = ~m_next;
        end
        wr(A_DATA, w);
      end else begin
        bit c;
        bit hit;
        c = 1'($urandom);
        hit = (q_s.size() > 0) && (q_c[0] == c);
        pop(c, a, s);
        chk("R6 random ack", 32'(a), 32'(hit));
        if (hit) begin
          chk("R3 R4 R5 R7 random data", 32'(s), 32'(q_s[0]));
          void'(q_s.pop_front());
          void'(q_c.pop_front());
        end
      end
    end

    done = 1;
    finish_up();
  end
endmodule